// File: doc/BRIEF.md
# Interrupt Blocking and Latching Controller

This block keeps the processor-level state bits that decide whether an incoming INIT, SMI or NMI may be taken at once. It also records whether the core is in system-management mode, halted or shut down. Event sources and the instruction pipeline drive single-cycle pulses into it. These are the asynchronous events (RESET, INIT, SMI, NMI, maskable interrupt), the completion of RSM, IRET and HLT, and a triple-fault indication. The block answers with a six-bit flag vector and a one-hot delivery strobe that the core acknowledges.

Every event kind has its own set and clear rules. A blocked INIT, SMI or NMI is not lost: one occurrence waits in a single-entry slot. It is handed over automatically once its block bit drops. Any further occurrences during the block are discarded. When several events qualify together, a fixed priority picks one. The strobe then stays up until it is acknowledged.

Top module: `intr_block_ctl`

## Requirements
- R1: After the reset input is released, `state_flags` and `deliver` are all zero. Flag bits are: [0] INIT blocked, [1] SMI blocked, [2] NMI blocked, [3] in SMM, [4] halted, [5] shut down.
- R2: A delivered SMI (`deliver` = 5'b00100) sets flag bits 0 to 3 and clears bits 4 and 5 on the same clock edge. No SMI is delivered while bit 1 is set.
- R3: `rsm_done` clears bits 0, 1 and 3, and also sets bit 4 when `rsm_halt_resume` is high. `iret_done` clears bits 0 and 2 only.
- R4: A delivered INIT (5'b00010) clears bits 1 to 5. No INIT is delivered while bit 0 is set.
- R5: A RESET event (5'b00001) is never blocked. Its delivery clears every flag and discards every waiting INIT, SMI and NMI.
- R6: While INIT, SMI or NMI cannot be delivered, one occurrence of each is held. Further occurrences before its delivery are lost.
- R7: A held event whose block bit clears on a clock edge is delivered on the following edge.
- R8: Among qualifying events, the order of preference is RESET, INIT, SMI, NMI, then maskable interrupt. `deliver` is at most one-hot.
- R9: A maskable interrupt (5'b10000) is delivered only if `intr_enable` is high in its pulse cycle and the strobe is free. Otherwise it is dropped and never held. Its delivery clears bit 4 and leaves bit 5.
- R10: `hlt_done` sets bit 4 and `triple_fault` sets bit 5. A delivered NMI (5'b01000) sets bit 2 and clears bits 4 and 5.
- R11: A non-zero `deliver` holds its value until an edge with `deliver_ack` high, which returns it to zero. No delivery is made on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_evt | input | 1 | RESET event pulse |
| init_evt | input | 1 | INIT event pulse |
| smi_evt | input | 1 | SMI event pulse |
| nmi_evt | input | 1 | NMI event pulse |
| intr_evt | input | 1 | Maskable interrupt pulse |
| intr_enable | input | 1 | Maskable interrupts permitted |
| rsm_done | input | 1 | RSM retired |
| iret_done | input | 1 | IRET retired |
| hlt_done | input | 1 | HLT retired |
| triple_fault | input | 1 | Triple fault detected |
| rsm_halt_resume | input | 1 | RSM re-enters the halted state |
| deliver_ack | input | 1 | Core has taken the strobed event |
| state_flags | output | 6 | Block and state flag vector |
| deliver | output | 5 | One-hot delivered event: [0] RESET, [1] INIT, [2] SMI, [3] NMI, [4] INTR |

## Verification
The hardest state to reach is one where a held event and a fresh pulse of the same kind meet on the edge that delivers the held one. In that state the fresh pulse must stay held and no third copy may appear. The same holds for a held SMI released by RSM while a held NMI stays blocked behind an SMI-set NMI block. Directed sequences build these states in steps: an SMI, then several NMIs and a second SMI while in SMM, then RSM and IRET in turn. A long random phase with sparse pulses and a random acknowledge then compares every cycle against a behavioural model. That phase reaches collisions between instruction completions and deliveries on the same edge.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
   localparam int NUM_EV      = 5;
   localparam int NUM_HELD    = 4;
   localparam int NUM_FLAGS   = 6;

   localparam int EV_RESET    = 0;
   localparam int EV_INIT     = 1;
   localparam int EV_SMI      = 2;
   localparam int EV_NMI      = 3;
   localparam int EV_INTR     = 4;

   localparam int FL_BLK_INIT = 0;
   localparam int FL_BLK_SMI  = 1;
   localparam int FL_BLK_NMI  = 2;
   localparam int FL_IN_SMM   = 3;
   localparam int FL_IN_HLT   = 4;
   localparam int FL_IN_SHUT  = 5;
endpackage

// File: rtl/lbl_hold.sv
// Single-entry holding slots, one per latchable event kind.
module lbl_hold #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pulse,
   input  logic [N-1:0] take,
   input  logic         flush,
   output logic [N-1:0] req
);
   logic [N-1:0] held_q;

   for (genvar i = 0; i < N; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          held_q[i] <= 1'b0;
         else if (flush)      held_q[i] <= 1'b0;
         else if (take[i])    held_q[i] <= held_q[i] & pulse[i];
         else                 held_q[i] <= held_q[i] | pulse[i];
      end
   end

   assign req = held_q | pulse;
endmodule

// File: rtl/lbl_arb.sv
// Fixed-priority pick: lowest index wins among unblocked requests.
module lbl_arb #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   input  logic [N-1:0] block,
   input  logic         busy,
   output logic [N-1:0] grant
);
   logic found;

   always_comb begin
      grant = '0;
      found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!found && !busy && req[i] && !block[i]) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lbl_flags.sv
module lbl_flags
   import lbl_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rsm,
   input  logic                 rsm_halt,
   input  logic                 iret,
   input  logic                 hlt,
   input  logic                 triple,
   input  logic [NUM_EV-1:0]    grant,
   output logic [NUM_FLAGS-1:0] flags
);
   logic [NUM_FLAGS-1:0] flags_q, nxt;

   always_comb begin
      nxt = flags_q;
      // retired instructions first
      if (rsm) begin
         nxt[FL_BLK_SMI]  = 1'b0;
         nxt[FL_BLK_INIT] = 1'b0;
         nxt[FL_IN_SMM]   = 1'b0;
         if (rsm_halt) nxt[FL_IN_HLT] = 1'b1;
      end
      if (iret) begin
         nxt[FL_BLK_NMI]  = 1'b0;
         nxt[FL_BLK_INIT] = 1'b0;
      end
      if (hlt)    nxt[FL_IN_HLT]  = 1'b1;
      if (triple) nxt[FL_IN_SHUT] = 1'b1;
      // a delivery on the same edge takes precedence
      if (grant[EV_RESET]) begin
         nxt = '0;
      end else if (grant[EV_INIT]) begin
         nxt[FL_BLK_SMI]  = 1'b0;
         nxt[FL_BLK_NMI]  = 1'b0;
         nxt[FL_IN_SMM]   = 1'b0;
         nxt[FL_IN_HLT]   = 1'b0;
         nxt[FL_IN_SHUT]  = 1'b0;
      end else if (grant[EV_SMI]) begin
         nxt[FL_BLK_INIT] = 1'b1;
         nxt[FL_BLK_SMI]  = 1'b1;
         nxt[FL_BLK_NMI]  = 1'b1;
         nxt[FL_IN_SMM]   = 1'b1;
         nxt[FL_IN_HLT]   = 1'b0;
         nxt[FL_IN_SHUT]  = 1'b0;
      end else if (grant[EV_NMI]) begin
         nxt[FL_BLK_NMI]  = 1'b1;
         nxt[FL_IN_HLT]   = 1'b0;
         nxt[FL_IN_SHUT]  = 1'b0;
      end else if (grant[EV_INTR]) begin
         nxt[FL_IN_HLT]   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= nxt;
   end

   assign flags = flags_q;
endmodule

// File: rtl/intr_block_ctl.sv
module intr_block_ctl
   import lbl_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reset_evt,
   input  logic                 init_evt,
   input  logic                 smi_evt,
   input  logic                 nmi_evt,
   input  logic                 intr_evt,
   input  logic                 intr_enable,
   input  logic                 rsm_done,
   input  logic                 iret_done,
   input  logic                 hlt_done,
   input  logic                 triple_fault,
   input  logic                 rsm_halt_resume,
   input  logic                 deliver_ack,
   output logic [NUM_FLAGS-1:0] state_flags,
   output logic [NUM_EV-1:0]    deliver
);
   if (EV_INTR != NUM_EV - 1 || NUM_HELD != EV_INTR) begin : g_bad_map
      $error("event index map inconsistent with slot count");
   end

   logic [NUM_HELD-1:0] held_pulse, held_req;
   logic [NUM_EV-1:0]   req, block, grant, deliver_q;
   logic                busy;

   assign held_pulse = {nmi_evt, smi_evt, init_evt, reset_evt};
   assign busy       = |deliver_q;

   lbl_hold #(.N(NUM_HELD)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .pulse (held_pulse),
      .take  (grant[NUM_HELD-1:0]),
      .flush (grant[EV_RESET]),
      .req   (held_req)
   );

   assign req = {intr_evt & intr_enable, held_req};

   always_comb begin
      block            = '0;
      block[EV_INIT]   = state_flags[FL_BLK_INIT];
      block[EV_SMI]    = state_flags[FL_BLK_SMI];
      block[EV_NMI]    = state_flags[FL_BLK_NMI];
   end

   lbl_arb #(.N(NUM_EV)) u_arb (
      .req   (req),
      .block (block),
      .busy  (busy),
      .grant (grant)
   );

   lbl_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rsm      (rsm_done),
      .rsm_halt (rsm_halt_resume),
      .iret     (iret_done),
      .hlt      (hlt_done),
      .triple   (triple_fault),
      .grant    (grant),
      .flags    (state_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              deliver_q <= '0;
      else if (busy)           deliver_q <= deliver_ack ? '0 : deliver_q;
      else                     deliver_q <= grant;
   end

   assign deliver = deliver_q;
endmodule

// File: rtl/lbl_chk.sv
module lbl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       intr_evt,
   input logic       intr_enable,
   input logic       deliver_ack,
   input logic [5:0] state_flags,
   input logic [4:0] deliver
);
   AST_DLV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(deliver)); // R8
   AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver != 5'd0 && !deliver_ack) |=> deliver == $past(deliver)); // R11
   AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver != 5'd0 && deliver_ack) |=> deliver == 5'd0); // R11
   AST_SMI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deliver[2]) |-> (state_flags == 6'h0F)); // R2
   AST_SMI_NOT_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deliver[2]) |-> !$past(state_flags[1])); // R2
   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deliver[1]) |-> (state_flags[5:1] == 5'd0)); // R4
   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deliver[0]) |-> (state_flags == 6'd0)); // R5
   AST_INTR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deliver[4]) |-> ($past(intr_evt) && $past(intr_enable))); // R9
endmodule

bind intr_block_ctl lbl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .intr_evt    (intr_evt),
   .intr_enable (intr_enable),
   .deliver_ack (deliver_ack),
   .state_flags (state_flags),
   .deliver     (deliver)
);

// File: tb/intr_block_ctl_bench.sv
module intr_block_ctl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reset_evt = 0, init_evt = 0, smi_evt = 0, nmi_evt = 0, intr_evt = 0;
   logic intr_enable = 0, rsm_done = 0, iret_done = 0, hlt_done = 0;
   logic triple_fault = 0, rsm_halt_resume = 0, deliver_ack = 0;
   logic [5:0] state_flags;
   logic [4:0] deliver;

   int n_vec = 0, n_bad = 0, cyc = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural reference
   logic [5:0] m_fl = '0;
   logic [3:0] m_hold = '0;
   logic [4:0] m_dlv = '0;

   always #5 clk = ~clk;

   intr_block_ctl u_intr_block_ctl (
      .clk(clk), .rst_n(rst_n), .reset_evt(reset_evt), .init_evt(init_evt),
      .smi_evt(smi_evt), .nmi_evt(nmi_evt), .intr_evt(intr_evt),
      .intr_enable(intr_enable), .rsm_done(rsm_done), .iret_done(iret_done),
      .hlt_done(hlt_done), .triple_fault(triple_fault),
      .rsm_halt_resume(rsm_halt_resume), .deliver_ack(deliver_ack),
      .state_flags(state_flags), .deliver(deliver));

   always @(posedge clk) begin
      logic [3:0] pl;
      logic [5:0] nf;
      int win;
      if (!rst_n) begin
         m_fl = '0; m_hold = '0; m_dlv = '0;
      end else begin
         pl = {nmi_evt, smi_evt, init_evt, reset_evt};
         win = -1;
         if (m_dlv == 0) begin
            if (m_hold[0] || pl[0]) win = 0;
            else if ((m_hold[1] || pl[1]) && !m_fl[0]) win = 1;
            else if ((m_hold[2] || pl[2]) && !m_fl[1]) win = 2;
            else if ((m_hold[3] || pl[3]) && !m_fl[2]) win = 3;
            else if (intr_evt && intr_enable) win = 4;
         end
         nf = m_fl;
         if (rsm_done) begin
            nf[0] = 0; nf[1] = 0; nf[3] = 0;
            if (rsm_halt_resume) nf[4] = 1;
         end
         if (iret_done) begin nf[0] = 0; nf[2] = 0; end
         if (hlt_done) nf[4] = 1;
         if (triple_fault) nf[5] = 1;
         case (win)
            0: nf = '0;
            1: nf = nf & 6'b000001;
            2: nf = 6'b001111;
            3: begin nf[2] = 1; nf[4] = 0; nf[5] = 0; end
            4: nf[4] = 0;
            default: ;
         endcase
         for (int k = 0; k < 4; k++)
            m_hold[k] = (win == k) ? (m_hold[k] & pl[k]) : (m_hold[k] | pl[k]);
         if (win == 0) m_hold = '0;
         if (m_dlv != 0) begin
            if (deliver_ack) m_dlv = '0;
         end else if (win >= 0) m_dlv = 5'd1 << win;
         m_fl = nf;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_vec++;
         if (deliver !== m_dlv || state_flags !== m_fl) begin
            n_bad++;
            $display("FAIL %s model: deliver=%b flags=%b expected deliver=%b flags=%b",
                     tag, deliver, state_flags, m_dlv, m_fl);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: cycles=%0d expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk); @(negedge clk);
      {reset_evt, init_evt, smi_evt, nmi_evt, intr_evt} = '0;
      {rsm_done, iret_done, hlt_done, triple_fault, deliver_ack} = '0;
   endtask

   task automatic chk(input string r, input logic [4:0] d_exp, input logic [5:0] f_exp);
      n_vec++;
      if (deliver !== d_exp || state_flags !== f_exp) begin
         n_bad++;
         $display("FAIL %s: deliver=%b flags=%b expected deliver=%b flags=%b",
                  r, deliver, state_flags, d_exp, f_exp);
      end
   endtask

   task automatic ack();
      deliver_ack = 1; tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; tick();
      chk("R1", 5'b0, 6'h00);

      tag = "R2"; smi_evt = 1; tick();
      chk("R2", 5'b00100, 6'h0F);
      ack();
      tag = "R6"; nmi_evt = 1; tick(); nmi_evt = 1; tick(); nmi_evt = 1; smi_evt = 1; tick();
      chk("R6", 5'b0, 6'h0F);
      tag = "R3"; rsm_done = 1; rsm_halt_resume = 1; tick(); rsm_halt_resume = 0;
      chk("R3", 5'b0, 6'h14);
      tag = "R7"; tick();
      chk("R7", 5'b00100, 6'h0F);
      ack();
      rsm_done = 1; tick();
      chk("R3", 5'b0, 6'h04);
      iret_done = 1; tick();
      chk("R3", 5'b0, 6'h00);
      tick();
      chk("R7", 5'b01000, 6'h04);
      ack(); iret_done = 1; tick(); tick(); tick();
      chk("R6", 5'b0, 6'h00);

      tag = "R8"; intr_enable = 1;
      init_evt = 1; smi_evt = 1; nmi_evt = 1; intr_evt = 1; tick();
      chk("R8", 5'b00010, 6'h00);
      tag = "R11"; intr_evt = 1; tick(); tick(); tick();
      chk("R11", 5'b00010, 6'h00);
      deliver_ack = 1; tick();
      chk("R11", 5'b0, 6'h00);
      tick();
      chk("R8", 5'b00100, 6'h0F);
      ack(); rsm_done = 1; tick(); iret_done = 1; tick(); tick();
      chk("R8", 5'b01000, 6'h04);
      ack(); iret_done = 1; tick();

      tag = "R9"; intr_enable = 0; intr_evt = 1; tick(); tick();
      chk("R9", 5'b0, 6'h00);
      tag = "R10"; hlt_done = 1; tick(); chk("R10", 5'b0, 6'h10);
      triple_fault = 1; tick(); chk("R10", 5'b0, 6'h30);
      tag = "R9"; intr_enable = 1; intr_evt = 1; tick();
      chk("R9", 5'b10000, 6'h20);
      ack();
      tag = "R10"; nmi_evt = 1; tick();
      chk("R10", 5'b01000, 6'h04);
      ack();
      tag = "R4"; hlt_done = 1; triple_fault = 1; tick();
      chk("R4", 5'b0, 6'h34);
      init_evt = 1; tick();
      chk("R4", 5'b00010, 6'h00);
      ack();

      tag = "R5"; smi_evt = 1; tick(); ack();
      nmi_evt = 1; init_evt = 1; tick();
      reset_evt = 1; tick();
      chk("R5", 5'b00001, 6'h00);
      ack(); tick(); tick();
      chk("R5", 5'b0, 6'h00);

      tag = "R6";
      for (int i = 0; i < 3000; i++) begin
         reset_evt       = ($urandom % 97) == 0;
         init_evt        = ($urandom % 9) == 0;
         smi_evt         = ($urandom % 9) == 0;
         nmi_evt         = ($urandom % 7) == 0;
         intr_evt        = ($urandom % 5) == 0;
         intr_enable     = ($urandom % 2) == 0;
         rsm_done        = ($urandom % 8) == 0;
         iret_done       = ($urandom % 8) == 0;
         hlt_done        = ($urandom % 11) == 0;
         triple_fault    = ($urandom % 13) == 0;
         rsm_halt_resume = ($urandom % 2) == 0;
         deliver_ack     = ($urandom % 3) != 0;
         @(posedge clk); @(negedge clk);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule